// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical address when no cached translation exists. It looks the address up in a flat, single-level page table in memory. A requester presents the virtual address, the kind of access (load, store or instruction fetch) and the table base address. The walker then issues one word read to a simple memory port.

Pages are 4 KB, so the upper 20 address bits select an entry and the lower 12 bits pass through untouched. Each entry is one 32-bit word. When the word comes back, the walker decodes three things from it:
- a residency flag,
- a two-bit permission field,
- a 20-bit physical frame number.

The walker then reports one of three results: success with a physical address, a missing page, or a disallowed access. It takes one request at a time. Other requests are refused while a walk is in progress.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `mem_rd_en`, `result` and `paddr` are all 0.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both high) raises `mem_rd_en` for exactly the next cycle. In that cycle `mem_rd_addr` equals `ptbr + 4 * req_vaddr[31:12]`, computed modulo 2^32 from the values at acceptance.
- R3: `req_ready` is 1 only when the walker is idle. It stays 0 from the cycle after acceptance through the cycle in which `done` is high.
- R3 (continued): `done` is high for exactly one cycle. That cycle immediately follows the first clock edge at which `mem_rd_valid` is seen while a read is outstanding. `mem_rd_valid` may already be high in the cycle in which `mem_rd_en` is high.
- R4: If entry bit 31 (the residency flag) is 0, `result` is 2'b01 (missing page) and `paddr` is 0. This holds whatever the permission bits contain, so a missing page takes priority over a permission failure.
- R5: Entry bits 21:20 hold the permission code: 00 none, 01 read-only, 10 read-write, 11 fetch-only. The access kind `req_kind` is coded 00 load, 01 store, 10 fetch, 11 reserved.
- R5 (continued): Read-only allows loads only. Read-write allows loads and stores. Fetch-only allows fetches only. None allows nothing, and the reserved kind is never allowed. For a resident entry, a disallowed access gives `result` 2'b10 and `paddr` 0.
- R6: A resident entry with an allowed access gives `result` 2'b00. `paddr` is then the entry's bits 19:0 followed by the request's address bits 11:0. Entry bits 30:22 have no effect.
- R7: While a walk is in progress, `req_valid` has no effect. No further read is issued, and the reported result belongs to the request that was accepted.
- R8: `mem_rd_valid` asserted while no read is outstanding has no effect. `done` stays 0 and the walker stays ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| ptbr | input | 32 | Byte address of the page table base |
| mem_rd_en | output | 1 | One-cycle read request to memory |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Returned table entry |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 missing page, 10 permission failure |
| paddr | output | 32 | Physical address; zero on failure |

## Verification
The missing-page check and the permission check both act on the same returned word in the same cycle. The bench returns non-resident entries whose permission bits would also reject the access. It expects the missing-page code every time, which confirms the priority. A second overlap occurs in the cycle the read is issued: the bench can return the read data in that same cycle. It also keeps `req_valid` high with a different address throughout each walk. The reported address and the count of issued reads must show that the stray request was ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } walk_state_t;

  typedef enum logic [1:0] {
    RES_OK         = 2'b00,
    RES_PAGE_FAULT = 2'b01,
    RES_PROT_FAULT = 2'b10
  } walk_result_t;

  localparam logic [1:0] ACC_LOAD  = 2'b00;
  localparam logic [1:0] ACC_STORE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  localparam logic [1:0] PERM_NONE  = 2'b00;
  localparam logic [1:0] PERM_RO    = 2'b01;
  localparam logic [1:0] PERM_RW    = 2'b10;
  localparam logic [1:0] PERM_FETCH = 2'b11;
endpackage

// File: rtl/walker_fsm.sv
module walker_fsm
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        rd_valid,
  output walk_state_t state,
  output logic        accept,
  output logic        finish
);
  walk_state_t nxt;

  always_comb begin
    nxt    = state;
    accept = 1'b0;
    finish = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          nxt    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (rd_valid) begin
          finish = 1'b1;
          nxt    = ST_DONE;
        end
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/pte_addr_gen.sv
module pte_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int VPN_W     = 20,
  parameter int PTE_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [ADDR_W-1:0] pte_addr
);
  // Entry index scaled to bytes; the sum wraps at the address width.
  logic [ADDR_W-1:0] byte_off;
  assign byte_off = ADDR_W'(vpn) << PTE_SHIFT;
  assign pte_addr = base + byte_off;
endmodule

// File: rtl/pte_decoder.sv
module pte_decoder
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int PPN_W = 20,
  parameter int OFF_W = 12,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       kind,
  input  logic [OFF_W-1:0] offset,
  output walk_result_t     res,
  output logic [PA_W-1:0]  pa
);
  // Layout: residency flag at the top bit, permission just above the frame number.
  localparam int PERM_LSB  = PPN_W;
  localparam int RESIDENT  = PTE_W - 1;

  logic             resident;
  logic [1:0]       perm;
  logic [PPN_W-1:0] frame;
  logic             allowed;
  logic             unused_rsvd;

  assign resident    = pte[RESIDENT];
  assign perm        = pte[PERM_LSB +: 2];
  assign frame       = pte[PPN_W-1:0];
  assign unused_rsvd = ^pte[RESIDENT-1:PERM_LSB+2];

  always_comb begin
    case (perm)
      PERM_RO:    allowed = (kind == ACC_LOAD);
      PERM_RW:    allowed = (kind == ACC_LOAD) || (kind == ACC_STORE);
      PERM_FETCH: allowed = (kind == ACC_FETCH);
      default:    allowed = 1'b0;
    endcase
  end

  always_comb begin
    pa = '0;
    if (!resident) begin
      res = RES_PAGE_FAULT;
    end else if (!allowed) begin
      res = RES_PROT_FAULT;
    end else begin
      res = RES_OK;
      pa  = {frame, offset};
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 20,
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] ptbr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [PTE_W-1:0]  mem_rd_data,
  output logic              done,
  output logic [1:0]        result,
  output logic [PA_W-1:0]   paddr
);
  walk_state_t       state;
  logic              accept;
  logic              finish;
  logic [ADDR_W-1:0] pte_addr_w;
  logic [OFF_W-1:0]  offset_q;
  logic [1:0]        kind_q;
  walk_result_t      dec_res;
  logic [PA_W-1:0]   dec_pa;

  walker_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .rd_valid (mem_rd_valid),
    .state    (state),
    .accept   (accept),
    .finish   (finish)
  );

  pte_addr_gen #(.ADDR_W(ADDR_W), .VPN_W(VPN_W), .PTE_SHIFT(2)) u_addr (
    .base    (ptbr),
    .vpn     (req_vaddr[VA_W-1:OFF_W]),
    .pte_addr(pte_addr_w)
  );

  pte_decoder #(.PTE_W(PTE_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_dec (
    .pte   (mem_rd_data),
    .kind  (kind_q),
    .offset(offset_q),
    .res   (dec_res),
    .pa    (dec_pa)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      offset_q    <= '0;
      kind_q      <= '0;
      done        <= 1'b0;
      result      <= RES_OK;
      paddr       <= '0;
    end else begin
      mem_rd_en <= accept;
      done      <= finish;
      if (accept) begin
        mem_rd_addr <= pte_addr_w;
        offset_q    <= req_vaddr[OFF_W-1:0];
        kind_q      <= req_kind;
      end
      if (finish) begin
        result <= dec_res;
        paddr  <= dec_pa;
      end
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 32,
  parameter int PA_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic [ADDR_W-1:0] ptbr,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_valid,
  input logic              done,
  input logic [1:0]        result,
  input logic [PA_W-1:0]   paddr
);
  logic [ADDR_W-1:0] exp_addr;
  assign exp_addr = ptbr + ({{(ADDR_W-VA_W+OFF_W){1'b0}}, req_vaddr[VA_W-1:OFF_W]} * 4);

  p_issue_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_rd_en && mem_rd_addr == $past(exp_addr)));

  p_single_read_r7: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  p_busy_on_read_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_on_done_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_ready);

  p_done_after_data_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_rd_valid));

  p_fault_zero_pa_r4: assert property (@(posedge clk) disable iff (rst)
    (done && result != 2'b00) |-> (paddr == '0));

  p_result_code_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (result != 2'b11));
endmodule

bind pt_walker pt_walker_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .PA_W(PA_W)
) u_chk (.*);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic [31:0] ptbr;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic        done;
  logic [1:0]  result;
  logic [31:0] paddr;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pt_walker u0 (.*);

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_res(input logic [31:0] pte, input logic [1:0] kind);
    logic ok;
    case (pte[21:20])
      2'b01:   ok = (kind == 2'b00);
      2'b10:   ok = (kind == 2'b00) || (kind == 2'b01);
      2'b11:   ok = (kind == 2'b10);
      default: ok = 1'b0;
    endcase
    if (!pte[31]) return 2'b01;
    return ok ? 2'b00 : 2'b10;
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] pte, input logic [1:0] kind, input logic [31:0] va);
    return (exp_res(pte, kind) == 2'b00) ? {pte[19:0], va[11:0]} : 32'h0;
  endfunction

  task automatic walk(input logic [31:0] va, input logic [1:0] kind, input logic [31:0] base,
                      input logic [31:0] pte, input int delay, input string tag);
    logic [31:0] ea;
    ea = base + {10'b0, va[31:12], 2'b00};
    @(negedge clk);
    chk(req_ready == 1'b1, {"R3 ready when idle ", tag}, req_ready, 1);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; ptbr = base;
    @(negedge clk);
    // stray request held during the walk (R7)
    req_vaddr = ~va; req_kind = ~kind; ptbr = ~base;
    chk(mem_rd_en == 1'b1, {"R2 read issued ", tag}, mem_rd_en, 1);
    chk(mem_rd_addr == ea, {"R2 entry address ", tag}, mem_rd_addr, ea);
    chk(req_ready == 1'b0, {"R3 busy after accept ", tag}, req_ready, 0);
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      chk(mem_rd_en == 1'b0, {"R7 no second read ", tag}, mem_rd_en, 0);
      chk(done == 1'b0, {"R3 no early done ", tag}, done, 0);
    end
    mem_rd_valid = 1'b1; mem_rd_data = pte;
    @(negedge clk);
    mem_rd_valid = 1'b0; mem_rd_data = $urandom; req_valid = 1'b0;
    chk(done == 1'b1, {"R3 done pulse ", tag}, done, 1);
    chk(result == exp_res(pte, kind), {"R4/R5/R6 result ", tag}, result, exp_res(pte, kind));
    chk(paddr == exp_pa(pte, kind, va), {"R4/R5/R6 paddr ", tag}, paddr, exp_pa(pte, kind, va));
    @(negedge clk);
    chk(done == 1'b0, {"R3 done falls ", tag}, done, 0);
    chk(req_ready == 1'b1, {"R3 ready again ", tag}, req_ready, 1);
    chk(mem_rd_en == 1'b0, {"R7 no stray read ", tag}, mem_rd_en, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; ptbr = '0;
    mem_rd_valid = 1'b0; mem_rd_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(mem_rd_en == 1'b0, "R1 rd_en", mem_rd_en, 0);
    chk(result == 2'b00, "R1 result", result, 0);
    chk(paddr == 32'h0, "R1 paddr", paddr, 0);

    // R8 unsolicited read data while idle
    mem_rd_valid = 1'b1; mem_rd_data = 32'h8030_1234;
    @(negedge clk);
    mem_rd_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R8 no done from stray data", done, 0);
    chk(req_ready == 1'b1, "R8 still ready", req_ready, 1);

    // Directed corners
    walk(32'h1234_5ABC, 2'b00, 32'h0010_0000, 32'h8012_3456, 0, "R6 RO load ok");
    walk(32'h0000_0FFF, 2'b00, 32'h0000_0000, 32'h0020_0001, 1, "R4 nonresident RW");
    walk(32'h0000_1000, 2'b01, 32'h0000_4000, 32'h0000_0002, 2, "R4 priority over none");
    walk(32'h4000_0010, 2'b01, 32'h0000_8000, 32'h8010_0001, 0, "R5 store to RO");
    walk(32'h4000_0010, 2'b00, 32'h0000_8000, 32'h8030_0001, 1, "R5 load from fetch-only");
    walk(32'h4000_0010, 2'b10, 32'h0000_8000, 32'h8030_ABCD, 0, "R5 fetch from fetch-only");
    walk(32'h4000_0010, 2'b10, 32'h0000_8000, 32'h8020_ABCD, 3, "R5 fetch from RW");
    walk(32'h4000_0010, 2'b11, 32'h0000_8000, 32'h8020_ABCD, 0, "R5 reserved kind");
    walk(32'h4000_0010, 2'b00, 32'h0000_8000, 32'h8000_ABCD, 0, "R5 none perm");
    walk(32'h7654_3210, 2'b01, 32'h0000_8000, 32'hFFE2_FFFF, 1, "R6 reserved bits ignored");
    walk(32'hFFFF_FFFF, 2'b01, 32'hFFFF_FFF0, 32'h802F_FFFF, 0, "R2 address wrap");

    // Constrained random walks
    for (int n = 0; n < 60; n++) begin
      logic [31:0] pte;
      pte = $urandom;
      pte[31] = ($urandom_range(3, 0) != 0);
      walk($urandom, 2'($urandom_range(2, 0)), {$urandom, 2'b00}, pte,
           $urandom_range(3, 0), "random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule